// File: doc/BRIEF.md
# Stereo Sample Playback Queue

This block buffers stereo audio for playback from a host that delivers samples in bursts. The host writes a 32-bit word with a channel select; the low half of the word is taken as one signed 16-bit sample and queued for that channel. Each channel keeps its samples in its own external single-port synchronous memory, used as a circular queue. A head pointer marks where the next sample lands and a tail pointer marks the next sample to play.

A free-running divider produces a playback tick. On each tick, each channel with queued data reads one sample and passes it to a first-order sigma-delta modulator. The modulator turns the sample into a one-bit pulse stream for an external low-pass filter. The host watches the per-channel fill level and tops the queue up in chunks. Writes that do not fit are dropped and raise a sticky overflow flag.

Each channel has a two-state control machine. CH_IDLE waits for a tick. The transition IDLE-to-CAPTURE is taken on a tick while the channel has committed data: the memory read is issued in that cycle. In CH_CAPTURE the read data is loaded into the modulator input, and the transition CAPTURE-to-IDLE is always taken after that one cycle. A tick that finds the channel empty keeps the state in CH_IDLE and loads zero into the modulator input.

Top module: `stereo_play_fifo`

## Requirements
- R1: While reset is asserted and right after it, both fill levels are 0, both overflow flags are 0, both pulse outputs are 0 and the tick output is 0.
- R2: A host write with `wr_valid` high queues `wr_data[15:0]` as one sample. `wr_chan` selects the channel (0 left, 1 right). Bits 31:16 have no effect on what is played.
- R3: Each fill level equals the number of samples committed to that channel's memory and not yet read: head minus tail, from 0 to 2^ADDR_W.
- R4: Both pointers wrap modulo 2^ADDR_W, with one extra bit that tells full from empty. Samples play in the order they were written, across any number of wraps.
- R5: A write is dropped in two cases: when committed plus held samples already equal 2^ADDR_W, or when it arrives in a playback-read cycle while the holding register is occupied. A dropped write sets that channel's overflow flag. The flag stays set until a cycle with `ovf_clr` high and no new drop; a drop in the same cycle as the clear wins.
- R6: `play_tick` is high for one cycle in every TICK_DIV cycles. It is first high in cycle TICK_DIV after reset is released.
- R7: In a tick cycle, a channel with committed data reads its tail entry, and the tail advances at that edge. The read sample becomes the modulator input one cycle later. A channel that is empty at a tick keeps its tail and sets its modulator input to zero. The modulator input holds its value between ticks.
- R8: A playback read takes the memory port before any write. A host write in a read cycle, or one that arrives while the holding register is occupied, goes into the one-entry holding register. The held sample is written in the next cycle without a read, and it is counted in the fill level from the edge it is written.
- R9: The modulator inverts the sample MSB to get offset binary. At every clock it adds this value to the low 16 bits of a 17-bit accumulator. The pulse output is the registered bit 16 of the accumulator.
- R10: Each channel makes one memory access per cycle. A write is indicated by `mem_*_we`; any cycle without it is a read of `mem_*_addr`, whose data is expected on `mem_*_rdata` after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host sample write strobe |
| wr_chan | input | 1 | Target channel, 0 left, 1 right |
| wr_data | input | 32 | Host write word, sample in bits 15:0 |
| ovf_clr | input | 1 | Clears both overflow flags |
| mem_l_addr | output | ADDR_W | Left memory address |
| mem_l_we | output | 1 | Left memory write enable |
| mem_l_wdata | output | 16 | Left memory write data |
| mem_l_rdata | input | 16 | Left memory read data, one cycle latency |
| mem_r_addr | output | ADDR_W | Right memory address |
| mem_r_we | output | 1 | Right memory write enable |
| mem_r_wdata | output | 16 | Right memory write data |
| mem_r_rdata | input | 16 | Right memory read data, one cycle latency |
| fill_l | output | ADDR_W+1 | Left fill level |
| fill_r | output | ADDR_W+1 | Right fill level |
| ovf_l | output | 1 | Left sticky overflow flag |
| ovf_r | output | 1 | Right sticky overflow flag |
| play_tick | output | 1 | Playback tick |
| sd_l | output | 1 | Left one-bit pulse stream |
| sd_r | output | 1 | Right one-bit pulse stream |

## Verification
The bench drives writes into tick cycles so that reads and writes collide on the port. A design that let the write win, or that lost the held sample, would shift or drop samples, and the pulse streams would then differ from the model. It fills a channel to its depth and beyond to exercise the drop rule, including a drop in the same cycle as a clear. A design that reported full one entry early or late, ignored the held entry, or let the clear win would show a wrong fill level or a wrong flag. Long mixed streams wrap the pointers many times, where a pointer without its extra bit would read back empty or stale data. Empty ticks check that the modulator input falls to zero and not to a stale sample.

// File: rtl/sp_fifo_pkg.sv
package sp_fifo_pkg;
    localparam int SAMPLE_W = 16;

    typedef enum logic {
        CH_IDLE    = 1'b0,
        CH_CAPTURE = 1'b1
    } ch_state_e;
endpackage

// File: rtl/sp_tick_div.sv
module sp_tick_div #(
    parameter int DIV = 748
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    // R6: a tick never lasts two cycles
    assert_tick_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/sp_sd_mod.sv
module sp_sd_mod
    import sp_fifo_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample,
    output logic                bit_out
);
    logic [SAMPLE_W:0] acc_q;
    logic [SAMPLE_W:0] offs;

    // R9: signed to offset binary by flipping the MSB
    assign offs    = {1'b0, ~sample[SAMPLE_W-1], sample[SAMPLE_W-2:0]};
    assign bit_out = acc_q[SAMPLE_W];

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= {1'b0, acc_q[SAMPLE_W-1:0]} + offs;
    end
endmodule

// File: rtl/sp_chan_queue.sv
module sp_chan_queue
    import sp_fifo_pkg::*;
#(
    parameter int AW = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                wr_hit,
    input  logic [SAMPLE_W-1:0] wr_sample,
    input  logic                ovf_clr,
    output logic [AW-1:0]       mem_addr,
    output logic                mem_we,
    output logic [SAMPLE_W-1:0] mem_wdata,
    input  logic [SAMPLE_W-1:0] mem_rdata,
    output logic [AW:0]         fill,
    output logic                ovf,
    output logic [SAMPLE_W-1:0] sample
);
    localparam int DEPTH = 1 << AW;
    localparam int OW    = AW + 2;

    ch_state_e           state_q, state_d;
    logic [AW:0]         head_q, tail_q, count;
    logic [OW-1:0]       occ;
    logic                hold_v_q, ovf_q;
    logic [SAMPLE_W-1:0] hold_d_q, sample_q;
    logic                empty, rd_go, accept, to_hold;

    always_comb begin
        count   = head_q - tail_q;
        empty   = (count == '0);
        occ     = {1'b0, count} + OW'(hold_v_q);
        rd_go   = tick && !empty && (state_q == CH_IDLE);
        // R5: drop on full or on a held entry that cannot drain this cycle
        accept  = wr_hit && (occ < OW'(DEPTH)) && !(rd_go && hold_v_q);
        to_hold = accept && (rd_go || hold_v_q);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // next state and memory port outputs; R8/R10: read owns the port
    always_comb begin
        state_d   = state_q;
        mem_addr  = tail_q[AW-1:0];
        mem_we    = 1'b0;
        mem_wdata = hold_d_q;
        unique case (state_q)
            CH_IDLE:    if (rd_go) state_d = CH_CAPTURE;
            CH_CAPTURE: state_d = CH_IDLE;
            default:    state_d = CH_IDLE;
        endcase
        if (!rd_go) begin
            if (hold_v_q) begin
                mem_we   = 1'b1;
                mem_addr = head_q[AW-1:0];
            end else if (accept) begin
                mem_we    = 1'b1;
                mem_addr  = head_q[AW-1:0];
                mem_wdata = wr_sample;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q   <= '0;
            tail_q   <= '0;
            hold_v_q <= 1'b0;
            hold_d_q <= '0;
            ovf_q    <= 1'b0;
            sample_q <= '0;
        end else begin
            head_q <= head_q + (AW+1)'(mem_we);
            tail_q <= tail_q + (AW+1)'(rd_go);
            if (to_hold) begin
                hold_v_q <= 1'b1;
                hold_d_q <= wr_sample;
            end else if (mem_we && hold_v_q) begin
                hold_v_q <= 1'b0;
            end
            if (wr_hit && !accept) ovf_q <= 1'b1;
            else if (ovf_clr)      ovf_q <= 1'b0;
            // R7: capture read data, or zero on an empty tick
            if (state_q == CH_CAPTURE)  sample_q <= mem_rdata;
            else if (tick && empty)     sample_q <= '0;
        end
    end

    assign fill   = count;
    assign ovf    = ovf_q;
    assign sample = sample_q;

    assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= (AW+1)'(DEPTH));
    assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !ovf_clr) |=> ovf_q);
    assert_capture_after_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_CAPTURE) |-> $past(tick));
    assert_empty_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && empty) |=> (sample_q == '0));
    assert_hold_drains_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_v_q && !rd_go) |=> (!hold_v_q || $past(wr_hit)));
endmodule

// File: rtl/stereo_play_fifo.sv
module stereo_play_fifo
    import sp_fifo_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int TICK_DIV = 748
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_valid,
    input  logic                wr_chan,
    input  logic [31:0]         wr_data,
    input  logic                ovf_clr,
    output logic [ADDR_W-1:0]   mem_l_addr,
    output logic                mem_l_we,
    output logic [15:0]         mem_l_wdata,
    input  logic [15:0]         mem_l_rdata,
    output logic [ADDR_W-1:0]   mem_r_addr,
    output logic                mem_r_we,
    output logic [15:0]         mem_r_wdata,
    input  logic [15:0]         mem_r_rdata,
    output logic [ADDR_W:0]     fill_l,
    output logic [ADDR_W:0]     fill_r,
    output logic                ovf_l,
    output logic                ovf_r,
    output logic                play_tick,
    output logic                sd_l,
    output logic                sd_r
);
    localparam int NCH = 2;

    logic                tick;
    logic [ADDR_W-1:0]   addr_a [NCH];
    logic                we_a   [NCH];
    logic [SAMPLE_W-1:0] wd_a   [NCH];
    logic [SAMPLE_W-1:0] rd_a   [NCH];
    logic [SAMPLE_W-1:0] smp_a  [NCH];
    logic [ADDR_W:0]     fill_a [NCH];
    logic                ovf_a  [NCH];
    logic                sd_a   [NCH];
    logic                unused_hi;

    // R2: the upper half of the host word carries nothing
    assign unused_hi = ^wr_data[31:16];

    sp_tick_div #(.DIV(TICK_DIV)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    assign rd_a[0] = mem_l_rdata;
    assign rd_a[1] = mem_r_rdata;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        sp_chan_queue #(.AW(ADDR_W)) u_q (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .wr_hit   (wr_valid && (wr_chan == 1'(c))),
            .wr_sample(wr_data[SAMPLE_W-1:0]),
            .ovf_clr  (ovf_clr),
            .mem_addr (addr_a[c]),
            .mem_we   (we_a[c]),
            .mem_wdata(wd_a[c]),
            .mem_rdata(rd_a[c]),
            .fill     (fill_a[c]),
            .ovf      (ovf_a[c]),
            .sample   (smp_a[c])
        );
        sp_sd_mod u_mod (
            .clk    (clk),
            .rst_n  (rst_n),
            .sample (smp_a[c]),
            .bit_out(sd_a[c])
        );
    end

    assign mem_l_addr  = addr_a[0];
    assign mem_l_we    = we_a[0];
    assign mem_l_wdata = wd_a[0];
    assign mem_r_addr  = addr_a[1];
    assign mem_r_we    = we_a[1];
    assign mem_r_wdata = wd_a[1];
    assign fill_l      = fill_a[0];
    assign fill_r      = fill_a[1];
    assign ovf_l       = ovf_a[0];
    assign ovf_r       = ovf_a[1];
    assign sd_l        = sd_a[0];
    assign sd_r        = sd_a[1];
    assign play_tick   = tick;
endmodule

// File: tb/stereo_play_fifo_bench.sv
module stereo_play_fifo_bench;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int DIV   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0, wr_chan = 1'b0, ovf_clr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [AW-1:0] mem_l_addr, mem_r_addr;
    logic mem_l_we, mem_r_we;
    logic [15:0] mem_l_wdata, mem_r_wdata, mem_l_rdata, mem_r_rdata;
    logic [AW:0] fill_l, fill_r;
    logic ovf_l, ovf_r, play_tick, sd_l, sd_r;

    always #5 clk = ~clk;

    stereo_play_fifo #(.ADDR_W(AW), .TICK_DIV(DIV)) u_stereo_play_fifo (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_chan(wr_chan),
        .wr_data(wr_data), .ovf_clr(ovf_clr),
        .mem_l_addr(mem_l_addr), .mem_l_we(mem_l_we), .mem_l_wdata(mem_l_wdata),
        .mem_l_rdata(mem_l_rdata),
        .mem_r_addr(mem_r_addr), .mem_r_we(mem_r_we), .mem_r_wdata(mem_r_wdata),
        .mem_r_rdata(mem_r_rdata),
        .fill_l(fill_l), .fill_r(fill_r), .ovf_l(ovf_l), .ovf_r(ovf_r),
        .play_tick(play_tick), .sd_l(sd_l), .sd_r(sd_r)
    );

    // R10: external synchronous single-port memories, one-cycle read latency
    logic [15:0] ram_l [DEPTH];
    logic [15:0] ram_r [DEPTH];
    always @(posedge clk) begin
        if (mem_l_we) ram_l[mem_l_addr] <= mem_l_wdata;
        mem_l_rdata <= ram_l[mem_l_addr];
        if (mem_r_we) ram_r[mem_r_addr] <= mem_r_wdata;
        mem_r_rdata <= ram_r[mem_r_addr];
    end

    // behavioural reference state
    int mq [2][$];
    int hold_v [2], hold_d [2], ovf_m [2], smp [2], cap_p [2], cap_v [2], acc [2];
    int cnt;
    int checks = 0, errors = 0;
    string phase = "R1";
    bit done = 0;

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s [%s] actual %0d expected %0d", tag, phase, got, exp);
        end
    endtask

    task automatic model_edge(input bit wv, input bit ch, input int data, input bit clr);
        bit tk;
        tk = (cnt == DIV - 1);
        for (int c = 0; c < 2; c++) begin
            int occ, nsmp, ohv;
            bit w, ok, rd;
            acc[c] = (acc[c] % 65536) + ((smp[c] & 16'hFFFF) ^ 16'h8000); // R9
            nsmp = smp[c];
            if (cap_p[c] != 0) begin nsmp = cap_v[c]; cap_p[c] = 0; end
            rd  = tk && (mq[c].size() > 0);
            occ = mq[c].size() + hold_v[c];
            ohv = hold_v[c];
            w   = wv && (ch == c[0]);
            ok  = w && (occ < DEPTH) && !(rd && ohv != 0);
            if (rd) begin cap_v[c] = mq[c].pop_front(); cap_p[c] = 1; end
            else if (tk) nsmp = 0;                                     // R7
            if (ohv != 0 && !rd) begin mq[c].push_back(hold_d[c]); hold_v[c] = 0; end
            if (ok) begin
                if (rd || ohv != 0) begin hold_v[c] = 1; hold_d[c] = data & 16'hFFFF; end // R8
                else mq[c].push_back(data & 16'hFFFF);
            end
            if (w && !ok) ovf_m[c] = 1;                                // R5
            else if (clr) ovf_m[c] = 0;
            smp[c] = nsmp;
        end
        cnt = tk ? 0 : cnt + 1;
    endtask

    task automatic compare();
        chk("R3 fill left", int'(fill_l), mq[0].size());
        chk("R3 fill right", int'(fill_r), mq[1].size());
        chk("R5 overflow left", int'(ovf_l), ovf_m[0]);
        chk("R5 overflow right", int'(ovf_r), ovf_m[1]);
        chk("R6 tick", int'(play_tick), int'(cnt == DIV - 1));
        chk("R9 pulse left", int'(sd_l), (acc[0] >> 16) & 1);
        chk("R9 pulse right", int'(sd_r), (acc[1] >> 16) & 1);
    endtask

    task automatic step(input bit wv, input bit ch, input int data, input bit clr);
        wr_valid = wv; wr_chan = ch; wr_data = data; ovf_clr = clr;
        @(posedge clk);
        model_edge(wv, ch, data, clr);
        @(negedge clk);
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0);
    endtask

    initial begin
        for (int c = 0; c < 2; c++) begin
            hold_v[c] = 0; hold_d[c] = 0; ovf_m[c] = 0; smp[c] = 0;
            cap_p[c] = 0; cap_v[c] = 0; acc[c] = 0;
        end
        cnt = 0;
        repeat (3) @(negedge clk);
        // R1: state under reset
        compare();
        rst_n = 1'b1;

        // R2: low half taken, channel routing, upper half ignored
        phase = "R2 routing";
        step(1, 0, 32'hABCD_1234, 0);
        step(1, 1, 32'hFFFF_8001, 0);
        step(1, 0, 32'h0000_7FFF, 0);
        step(1, 1, 32'h5A5A_0000, 0);
        idle(40);

        // R7: empty ticks drive zero into the modulator
        phase = "R7 empty";
        idle(30);

        // R5: overflow on full, sticky, clear, drop beats clear
        phase = "R5 full";
        for (int i = 0; i < 22; i++) step(1, 0, 1000 * i + 7, 0);
        idle(3);
        step(0, 0, 0, 1);
        for (int i = 0; i < 20; i++) step(1, 0, 32'h0000_F000 + i, 0);
        step(1, 0, 32'h0000_0055, 1);
        idle(2);
        step(0, 0, 0, 1);
        idle(150);

        // R8: writes landing on read ticks, and back-to-back runs across ticks
        phase = "R8 collide";
        for (int k = 0; k < 6; k++) step(1, 1, 300 + k, 0);
        for (int k = 0; k < 6; k++) begin
            while (play_tick !== 1'b1) step(0, 0, 0, 0);
            step(1, 1, 32'h0000_4000 + k, 0);
        end
        for (int k = 0; k < 30; k++) step(1, k[0], 32'h0000_2000 + 37 * k, 0);
        step(0, 0, 0, 1);
        idle(60);

        // R4: long mixed stream, many pointer wraps
        phase = "R4 wrap";
        for (int i = 0; i < 500; i++) begin
            int v;
            v = (i * 40503 + 12345) & 32'h7FFF_FFFF;
            step((i % 3) != 0, i[1], v, (i % 97) == 0);
        end
        idle(300);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog [%s] actual 0 expected 1", phase);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule